// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt Logic

This block watches two comparator results that arrive with no timing relation to the system clock. Each result is brought into the clock domain by a two-flop synchronizer. It can then be inverted by a per-channel control bit, and it is shown as a read-only status bit in an 8-bit comparator control register. The interrupt logic does not look for edges. It keeps a snapshot of both reported outputs, taken whenever software reads or writes the control register. For as long as either live output differs from its snapshot, a sticky interrupt flag is set on every clock.

Software clears the condition in two steps. It first accesses the control register, which refreshes the snapshot and ends the mismatch. It then writes 0 to the flag. Writing 1 to the flag raises it on purpose. The flag drives the interrupt request only when three enable bits are all 1: a local one, a peripheral one and a global one. The flag itself is set whatever the enables hold. Analog comparison, reference generation and pin routing are not part of this block.

In this implementation a snapshot taken in the same cycle as an output change captures the value that was synchronized before the change. The new value then shows a mismatch one cycle later and sets the flag. The case where the flag might stay clear therefore does not arise here.

Top module: `cmp_chg_irq`

## Requirements
- R1: A change on `cmp_raw_i[k]` appears in the status field of `ctrl_rdata_o` after exactly two rising clock edges. Comparator 0 reports on bit 6 and comparator 1 on bit 7.
- R2: A control write (`reg_wr_i`=1) stores `reg_wdata_i[4]` as the invert bit of comparator 0 and `reg_wdata_i[5]` as the invert bit of comparator 1. These bits read back on `ctrl_rdata_o[5:4]` and invert the matching reported output. `ctrl_rdata_o[3:0]` always reads 0.
- R3: When a reported output differs from its snapshot, `flag_o` is 1 after the next rising edge.
- R4: A control read (`reg_rd_i`=1) or control write loads the snapshot with the reported outputs as they stand after the access, which ends the mismatch.
- R5: While a mismatch persists, writing 0 to the flag does not leave it clear. Once the register has been accessed and the outputs are steady, the clear takes effect.
- R6: With no mismatch, a flag write (`flag_wr_i`=1) loads `flag_wdata_i` into `flag_o`. Writing 1 sets the flag, and writing 0 clears it.
- R7: If a mismatch and a flag write of 0 fall in the same cycle, the flag ends up 1.
- R8: `irq_o` is 1 only when `flag_o` is 1 and all three enable bits are 1. An enable write (`en_wr_i`=1) loads `en_wdata_i`: bit 0 is the local enable, bit 1 the peripheral enable and bit 2 the global enable.
- R9: A mismatch sets `flag_o` even when some or all enable bits are 0.
- R10: After reset, `ctrl_rdata_o` is 0, `flag_o` is 0, `irq_o` is 0 and all enable bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmp_raw_i | input | 2 | Asynchronous comparator results |
| reg_rd_i | input | 1 | Read strobe of the control register |
| reg_wr_i | input | 1 | Write strobe of the control register |
| reg_wdata_i | input | 8 | Write data of the control register |
| flag_wr_i | input | 1 | Write strobe of the interrupt flag |
| flag_wdata_i | input | 1 | Value written to the flag |
| en_wr_i | input | 1 | Write strobe of the enable bits |
| en_wdata_i | input | 3 | Enable values: local, peripheral, global |
| ctrl_rdata_o | output | 8 | Control register read value |
| flag_o | output | 1 | Sticky interrupt flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
A wrong snapshot shows up at the ports one edge after the next steady cycle. Either `flag_o` rises with no output change, or it stays low after one. A wrong synchronizer or invert state moves the status bits a cycle early or late, or inverts them. A wrong enable state shows on `irq_o` in the first cycle the flag is up. The bench compares all three outputs with a cycle-accurate model on every clock, so it sees each of these faults within one or two cycles of the stimulus that exposes it.

// File: rtl/cmp_chg_pkg.sv
package cmp_chg_pkg;
    localparam int EN_W = 3;
    localparam int EN_LOCAL  = 0;
    localparam int EN_PERIPH = 1;
    localparam int EN_GLOBAL = 2;

    typedef struct packed {
        logic            flag;
        logic [EN_W-1:0] en;
    } flag_state_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] stage_d [STAGES];
    logic [N-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cmp_snap.sv
module cmp_snap #(
    parameter int N     = 2,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     sync_i,
    input  logic             reg_rd_i,
    input  logic             reg_wr_i,
    input  logic [N-1:0]     inv_wdata_i,
    output logic [REG_W-1:0] ctrl_rdata_o,
    output logic             mismatch_o
);
    localparam int PAD_W = REG_W - 2*N;

    typedef struct packed {
        logic [N-1:0] inv;
        logic [N-1:0] snap;
    } snap_state_t;

    snap_state_t  st_d, st_q;
    logic [N-1:0] live;

    always_comb begin
        st_d = st_q;
        live = sync_i ^ st_q.inv;
        if (reg_wr_i) st_d.inv = inv_wdata_i;
        if (reg_rd_i || reg_wr_i) st_d.snap = sync_i ^ st_d.inv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mismatch_o   = |(live ^ st_q.snap);
    assign ctrl_rdata_o = {live, st_q.inv, {PAD_W{1'b0}}};
endmodule

// File: rtl/cmp_flag.sv
module cmp_flag
    import cmp_chg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mismatch_i,
    input  logic            flag_wr_i,
    input  logic            flag_wdata_i,
    input  logic            en_wr_i,
    input  logic [EN_W-1:0] en_wdata_i,
    output logic            flag_o,
    output logic            irq_o
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_wr_i)    st_d.en   = en_wdata_i;
        if (flag_wr_i)  st_d.flag = flag_wdata_i;
        if (mismatch_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & st_q.en[EN_LOCAL] & st_q.en[EN_PERIPH] & st_q.en[EN_GLOBAL];
endmodule

// File: rtl/cmp_chg_irq.sv
module cmp_chg_irq
    import cmp_chg_pkg::*;
#(
    parameter int N_CMP       = 2,
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CMP-1:0] cmp_raw_i,
    input  logic             reg_rd_i,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    input  logic             flag_wr_i,
    input  logic             flag_wdata_i,
    input  logic             en_wr_i,
    input  logic [EN_W-1:0]  en_wdata_i,
    output logic [REG_W-1:0] ctrl_rdata_o,
    output logic             flag_o,
    output logic             irq_o
);
    localparam int INV_LSB = REG_W - 2*N_CMP;

    logic [N_CMP-1:0] sync_w;
    logic             mismatch_w;
    logic             unused_wbits;

    assign unused_wbits = ^{reg_wdata_i[REG_W-1 -: N_CMP], reg_wdata_i[INV_LSB-1:0]};

    cmp_sync #(.N(N_CMP), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_raw_i),
        .sync_o  (sync_w)
    );

    cmp_snap #(.N(N_CMP), .REG_W(REG_W)) snap_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_i       (sync_w),
        .reg_rd_i     (reg_rd_i),
        .reg_wr_i     (reg_wr_i),
        .inv_wdata_i  (reg_wdata_i[INV_LSB +: N_CMP]),
        .ctrl_rdata_o (ctrl_rdata_o),
        .mismatch_o   (mismatch_w)
    );

    cmp_flag flag_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mismatch_i   (mismatch_w),
        .flag_wr_i    (flag_wr_i),
        .flag_wdata_i (flag_wdata_i),
        .en_wr_i      (en_wr_i),
        .en_wdata_i   (en_wdata_i),
        .flag_o       (flag_o),
        .irq_o        (irq_o)
    );
endmodule

// File: rtl/cmp_chg_irq_chk.sv
module cmp_chg_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_i,
    input logic       flag_wr_i,
    input logic       flag_wdata_i,
    input logic [7:0] ctrl_rdata_o,
    input logic       flag_o,
    input logic       irq_o,
    input logic       mismatch
);
    p_flag_on_mismatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> flag_o);

    p_hw_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && flag_wr_i && !flag_wdata_i) |=> flag_o);

    p_sw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr_i && flag_wdata_i) |=> flag_o);

    p_sw_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr_i && !flag_wdata_i && !mismatch) |=> !flag_o);

    p_flag_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(mismatch || (flag_wr_i && flag_wdata_i)));

    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);

    p_inv_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_wr_i) |-> $stable(ctrl_rdata_o[5:4]));

    p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata_o[3:0] == 4'b0000);
endmodule

bind cmp_chg_irq cmp_chg_irq_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_i     (reg_wr_i),
    .flag_wr_i    (flag_wr_i),
    .flag_wdata_i (flag_wdata_i),
    .ctrl_rdata_o (ctrl_rdata_o),
    .flag_o       (flag_o),
    .irq_o        (irq_o),
    .mismatch     (mismatch_w)
);

// File: tb/cmp_chg_irq_tb_top.sv
module cmp_chg_irq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmp_raw_i = '0;
    logic       reg_rd_i = 1'b0, reg_wr_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic       flag_wr_i = 1'b0, flag_wdata_i = 1'b0;
    logic       en_wr_i = 1'b0;
    logic [2:0] en_wdata_i = '0;
    logic [7:0] ctrl_rdata_o;
    logic       flag_o, irq_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    logic [1:0] m_s1 = '0, m_s2 = '0, m_inv = '0, m_snap = '0;
    logic       m_flag = 1'b0;
    logic [2:0] m_en = '0;

    always #5 clk = ~clk;

    cmp_chg_irq dut_i (.*);

    function automatic logic [7:0] exp_rdata();
        return {m_s2 ^ m_inv, m_inv, 4'b0000};
    endfunction

    function automatic logic exp_irq();
        return m_flag & (&m_en);
    endfunction

    task automatic model_step();
        logic       mis;
        logic [1:0] ninv;
        mis  = ((m_s2 ^ m_inv) != m_snap);
        ninv = reg_wr_i ? reg_wdata_i[5:4] : m_inv;
        if (reg_rd_i || reg_wr_i) m_snap = m_s2 ^ ninv;
        m_inv = ninv;
        if (flag_wr_i) m_flag = flag_wdata_i;
        if (mis) m_flag = 1'b1;
        if (en_wr_i) m_en = en_wdata_i;
        m_s2 = m_s1;
        m_s1 = cmp_raw_i;
    endtask

    task automatic check_all(string tag);
        n_chk += 3;
        if (ctrl_rdata_o !== exp_rdata()) begin
            n_bad++;
            $display("FAIL %s ctrl_rdata act=%h exp=%h", tag, ctrl_rdata_o, exp_rdata());
        end
        if (flag_o !== m_flag) begin
            n_bad++;
            $display("FAIL %s flag act=%b exp=%b", tag, flag_o, m_flag);
        end
        if (irq_o !== exp_irq()) begin
            n_bad++;
            $display("FAIL %s irq act=%b exp=%b", tag, irq_o, exp_irq());
        end
    endtask

    // inputs are set at a falling edge; the model takes the coming rising edge; check at the next falling edge
    task automatic step(string tag);
        model_step();
        @(negedge clk);
        check_all(tag);
        reg_rd_i = 0; reg_wr_i = 0; flag_wr_i = 0; en_wr_i = 0;
    endtask

    task automatic expect_bit(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_all("R10 reset");
        rst_n = 1'b1;
        step("R10 idle");

        // R1: comparator 0 rises, seen after two edges on bit 6
        cmp_raw_i = 2'b01;
        step("R1 edge1");
        expect_bit("R1 not yet", ctrl_rdata_o[6], 1'b0);
        step("R1 edge2");
        expect_bit("R1 bit6", ctrl_rdata_o[6], 1'b1);
        // R3/R9: mismatch sets flag though enables are 0
        step("R3 flag set");
        expect_bit("R9 flag with enables off", flag_o, 1'b1);
        expect_bit("R8 no irq", irq_o, 1'b0);

        // R5: clear without access fails
        flag_wr_i = 1; flag_wdata_i = 0;
        step("R5 clear blocked");
        expect_bit("R5 flag stays", flag_o, 1'b1);
        // R4: read latches snapshot
        reg_rd_i = 1;
        step("R4 read");
        flag_wr_i = 1; flag_wdata_i = 0;
        step("R5 clear after read");
        expect_bit("R5 flag cleared", flag_o, 1'b0);

        // R6: software set
        flag_wr_i = 1; flag_wdata_i = 1;
        step("R6 sw set");
        expect_bit("R6 set", flag_o, 1'b1);
        // R8: enable all
        en_wr_i = 1; en_wdata_i = 3'b111;
        step("R8 enable");
        expect_bit("R8 irq", irq_o, 1'b1);
        en_wr_i = 1; en_wdata_i = 3'b011;
        step("R8 global off");
        expect_bit("R8 irq gated", irq_o, 1'b0);

        // R2: invert comparator 1 via bit 5
        reg_wr_i = 1; reg_wdata_i = 8'hFF & 8'b0010_0000;
        step("R2 invert write");
        expect_bit("R2 bit7 inverted", ctrl_rdata_o[7], 1'b1);
        expect_bit("R2 inv readback", ctrl_rdata_o[5], 1'b1);

        // R7: comparator 1 rises, hit clear in the mismatch cycle
        flag_wr_i = 1; flag_wdata_i = 0;
        step("R6 clear");
        cmp_raw_i = 2'b11;
        step("R7 a");
        step("R7 b");
        flag_wr_i = 1; flag_wdata_i = 0;
        step("R7 hw wins");
        expect_bit("R7 flag", flag_o, 1'b1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(9) == 0) cmp_raw_i = 2'($urandom);
            reg_rd_i     = ($urandom_range(7) == 0);
            reg_wr_i     = ($urandom_range(15) == 0);
            reg_wdata_i  = 8'($urandom);
            flag_wr_i    = ($urandom_range(7) == 0);
            flag_wdata_i = 1'($urandom);
            en_wr_i      = ($urandom_range(15) == 0);
            en_wdata_i   = ($urandom_range(1) == 0) ? 3'b111 : 3'($urandom);
            step("R3 R4 R8 random");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D));
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule